// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It oversamples the line with a sixteen-times tick enable supplied from outside. After a falling edge, it checks at half a bit time that the start bit is genuine. It then samples each data bit, the optional parity bit and the first stop bit at the centre of its bit cell. Least significant bit comes first on the line.

A 6-bit format word sets the character shape. It is captured when a start edge is accepted and is held for the whole character. The word selects the number of data bits, the stop length, whether a parity bit is present, and how that parity bit is judged. Each character is reported with a one-clock strobe. A zero-extended data byte and two error flags come with it. These outputs keep their values until the next strobe.

The line passes through a two-flop synchronizer before edge detection. After the first stop bit is sampled, the receiver waits out the rest of the programmed stop time and then re-arms.

Top module: `uart_rx_fmt`

## Requirements
- R1: Format bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data is received least significant bit first and placed right-aligned in the output byte. Output bits above the selected length read 0.
- R2: With format bit [3] = 0, no parity bit is sampled and the cell after the last data bit is taken as the stop bit. The parity error flag stays 0 in this case.
- R3: With bits [3]=1, [5]=0 and [4]=0 (odd), the parity flag is set when the data bits plus the received parity bit hold an even number of ones.
- R4: With bits [3]=1, [5]=0 and [4]=1 (even), the parity flag is set when the data bits plus the received parity bit hold an odd number of ones.
- R5: With bits [3]=1 and [5]=1, the parity bit must be 1 when bit [4]=0 and must be 0 when bit [4]=1. Any other value sets the parity flag.
- R6: Format bit [2]=0 gives one stop bit. Bit [2]=1 gives 1.5 stop bits for 5-bit data and 2 stop bits otherwise. Only the first stop bit is checked, so a low second stop bit causes no error.
- R7: A low level at the centre of the first stop bit sets the framing error flag for that character.
- R8: A low pulse on the line that is high again 8 ticks after its falling edge is a false start. It produces no strobe, and the receiver returns to idle.
- R9: The valid strobe is exactly one clock wide. Data and both flags change only in the strobe cycle and hold their values until the next strobe.
- R10: While reset is asserted, the strobe, the data byte and both flags are 0. A reset applied in the middle of a character abandons that character, and the next character is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high, asynchronous to clk |
| tick16_en | input | 1 | One-clock enable at sixteen times the bit rate |
| line_ctl | input | 6 | Format word: [1:0] length, [2] stop, [3] parity enable, [4] parity select, [5] forced parity |
| rx_byte | output | 8 | Received character, zero-extended |
| rx_strobe | output | 1 | One-clock strobe marking a new character |
| rx_par_err | output | 1 | Parity error for the last character |
| rx_frm_err | output | 1 | Framing error for the last character |

## Verification
Characters are sent in all four data lengths, each with bit patterns that would give a different result if bits were swapped or truncated. Each parity mode is sent once with a correct parity bit and once with a wrong one, so a mode that checks the wrong sense or ignores the bit is caught. Stop-bit patterns include a low first stop, a low second stop and the 1.5-stop length, which separates the checked stop bit from the waited-out stop time. A short low glitch and a reset during a character are used to confirm that neither produces a strobe, and that the following character is received correctly.

// File: rtl/uart_rx_fmt_pkg.sv
package uart_rx_fmt_pkg;

  // Format word; packed MSB first so it maps directly onto line_ctl[5:0].
  typedef struct packed {
    logic       force_par;  // [5] parity bit forced to a fixed level
    logic       par_sel;    // [4] even (or forced-space) when set
    logic       par_en;     // [3] parity cell present
    logic       long_stop;  // [2] extended stop time
    logic [1:0] wlen;       // [1:0] data length minus five
  } rx_fmt_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_t;

  localparam int unsigned MIN_BITS = 5;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
  import uart_rx_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  rx_fmt_t           fmt,
  output logic              par_err
);

  logic odd_ones;

  // Unused upper data bits are held at zero by the core, so the full width can be folded.
  always_comb begin
    odd_ones = ^{data, par_bit};
    case ({fmt.force_par, fmt.par_sel})
      2'b00:   par_err = ~odd_ones;  // odd sense: even count is wrong
      2'b01:   par_err =  odd_ones;  // even sense: odd count is wrong
      2'b10:   par_err = ~par_bit;   // must be mark
      default: par_err =  par_bit;   // must be space
    endcase
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_fmt_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  rx_fmt_t           fmt_in,
  input  logic              par_err,
  output logic [DATA_W-1:0] chk_data,
  output logic              chk_bit,
  output rx_fmt_t           chk_fmt,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_perr,
  output logic              rx_ferr
);

  localparam int unsigned HALF   = OVS / 2;
  localparam int unsigned CNT_W  = $clog2(2 * OVS);
  localparam int unsigned BIDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HOLD_ONE  = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] HOLD_ONEH = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HOLD_TWO  = CNT_W'(OVS + HALF - 1);

  rx_state_t         state_q, state_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              par_q, par_d;
  rx_fmt_t           fmt_q, fmt_d;
  logic              rxd_q;
  logic              fall;
  logic [BIDX_W-1:0] last_idx;
  logic [CNT_W-1:0]  hold_last;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;

  assign fall     = rxd_q & ~rxd_s;
  assign last_idx = BIDX_W'(MIN_BITS - 1) + BIDX_W'(fmt_q.wlen);

  always_comb begin
    if (!fmt_q.long_stop)      hold_last = HOLD_ONE;
    else if (fmt_q.wlen == '0) hold_last = HOLD_ONEH;
    else                       hold_last = HOLD_TWO;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bidx_d  = bidx_q;
    shreg_d = shreg_q;
    par_d   = par_q;
    fmt_d   = fmt_q;
    valid_d = 1'b0;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    case (state_q)
      S_IDLE: begin
        if (fall) begin
          state_d = S_START;
          tcnt_d  = '0;
          bidx_d  = '0;
          shreg_d = '0;
          par_d   = 1'b0;
          fmt_d   = fmt_in;
        end
      end
      S_START: begin
        if (tick) begin
          if (tcnt_q == HALF_LAST) begin
            tcnt_d  = '0;
            state_d = rxd_s ? S_IDLE : S_DATA;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (tick) begin
          if (tcnt_q == BIT_LAST) begin
            tcnt_d          = '0;
            shreg_d[bidx_q] = rxd_s;
            if (bidx_q == last_idx) state_d = fmt_q.par_en ? S_PAR : S_STOP;
            else                    bidx_d  = bidx_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      S_PAR: begin
        if (tick) begin
          if (tcnt_q == BIT_LAST) begin
            tcnt_d  = '0;
            par_d   = rxd_s;
            state_d = S_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tick) begin
          if (tcnt_q == BIT_LAST) begin
            tcnt_d  = '0;
            valid_d = 1'b1;
            data_d  = shreg_q;
            perr_d  = fmt_q.par_en & par_err;
            ferr_d  = ~rxd_s;
            state_d = S_HOLD;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      S_HOLD: begin
        if (tick) begin
          if (tcnt_q == hold_last) state_d = S_IDLE;
          else                     tcnt_d  = tcnt_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      fmt_q   <= '0;
      rxd_q   <= 1'b1;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
      fmt_q   <= fmt_d;
      rxd_q   <= rxd_s;
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign chk_data = shreg_q;
  assign chk_bit  = par_q;
  assign chk_fmt  = fmt_q;
  assign rx_data  = data_q;
  assign rx_valid = valid_q;
  assign rx_perr  = perr_q;
  assign rx_ferr  = ferr_q;

  // R9: strobe never lasts two clocks
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R9: reported values move only together with the strobe
  p_outputs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(data_q) && $stable(perr_q) && $stable(ferr_q)));

  // R1: five-bit characters leave the upper byte bits clear
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && fmt_q.wlen == 2'b00) |-> (data_q[DATA_W-1:MIN_BITS] == '0));

  // R2: no parity cell means no parity error
  p_no_par_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !fmt_q.par_en) |-> !perr_q);

  // R7: framing flag reflects the level seen at the first stop centre
  p_ferr_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOP && tick && tcnt_q == BIT_LAST) |=> (ferr_q == !$past(rxd_s)));

  // R8: a high line at the start check sends the receiver back to idle
  p_false_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && tick && tcnt_q == HALF_LAST && rxd_s) |=> (state_q == S_IDLE));

endmodule

// File: rtl/uart_rx_fmt.sv
module uart_rx_fmt
  import uart_rx_fmt_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16_en,
  input  logic [5:0]        line_ctl,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_strobe,
  output logic              rx_par_err,
  output logic              rx_frm_err
);

  logic              line_s;
  logic              par_err;
  logic [DATA_W-1:0] chk_data;
  logic              chk_bit;
  rx_fmt_t           chk_fmt;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  uart_rx_core #(.OVS(OVS), .DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16_en),
    .rxd_s   (line_s),
    .fmt_in  (rx_fmt_t'(line_ctl)),
    .par_err (par_err),
    .chk_data(chk_data),
    .chk_bit (chk_bit),
    .chk_fmt (chk_fmt),
    .rx_data (rx_byte),
    .rx_valid(rx_strobe),
    .rx_perr (rx_par_err),
    .rx_ferr (rx_frm_err)
  );

  uart_rx_parity #(.DATA_W(DATA_W)) u_parity (
    .data   (chk_data),
    .par_bit(chk_bit),
    .fmt    (chk_fmt),
    .par_err(par_err)
  );

endmodule

// File: tb/uart_rx_fmt_tb.sv
module uart_rx_fmt_tb;

  typedef struct packed {
    logic [5:0] ctl;
    logic [7:0] din;
    logic       pbit;
    logic       s1_low;
    logic       s2_low;
    logic [7:0] exp_d;
    logic       exp_pe;
    logic       exp_fe;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 19;
  // ctl = {force, sel, par_en, long_stop, wlen[1:0]}
  localparam vec_t VECS [NVEC] = '{
    '{6'b000011, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 4'd1},  // R1 8 bits
    '{6'b000000, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 4'd1},  // R1 5 bits
    '{6'b000001, 8'hEA, 1'b0, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 4'd1},  // R1 6 bits
    '{6'b000010, 8'hDB, 1'b0, 1'b0, 1'b0, 8'h5B, 1'b0, 1'b0, 4'd1},  // R1 7 bits
    '{6'b000010, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0, 4'd2},  // R2 no parity
    '{6'b001011, 8'h03, 1'b1, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 4'd3},  // R3 odd ok
    '{6'b001011, 8'h03, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 4'd3},  // R3 odd bad
    '{6'b011011, 8'h07, 1'b1, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 4'd4},  // R4 even ok
    '{6'b011011, 8'h07, 1'b0, 1'b0, 1'b0, 8'h07, 1'b1, 1'b0, 4'd4},  // R4 even bad
    '{6'b101011, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 mark ok
    '{6'b101011, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd5},  // R5 mark bad
    '{6'b111011, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 space ok
    '{6'b111011, 8'h81, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 1'b0, 4'd5},  // R5 space bad
    '{6'b000011, 8'h55, 1'b0, 1'b1, 1'b0, 8'h55, 1'b0, 1'b1, 4'd7},  // R7 stop low
    '{6'b000110, 8'hB3, 1'b0, 1'b0, 1'b1, 8'h33, 1'b0, 1'b0, 4'd6},  // R6 second stop low
    '{6'b000100, 8'h15, 1'b0, 1'b0, 1'b0, 8'h15, 1'b0, 1'b0, 4'd6},  // R6 1.5 stop
    '{6'b001000, 8'h1F, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 4'd3},  // R3 five bits
    '{6'b011001, 8'h01, 1'b1, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 4'd7},  // R7 with parity
    '{6'b001010, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd3}   // R3 zero ones
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16_en = 1'b0;
  logic [5:0] line_ctl = 6'b000011;
  logic [7:0] rx_byte;
  logic       rx_strobe;
  logic       rx_par_err;
  logic       rx_frm_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] tdiv = 2'd0;
  int         cap_cnt = 0;
  int         run = 0;
  int         max_run = 0;
  logic [7:0] cap_d = '0;
  logic       cap_pe = 1'b0;
  logic       cap_fe = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  uart_rx_fmt u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .tick16_en (tick16_en),
    .line_ctl  (line_ctl),
    .rx_byte   (rx_byte),
    .rx_strobe (rx_strobe),
    .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err)
  );

  // Tick every fourth clock: one bit cell is 64 clocks.
  always @(negedge clk) begin
    tdiv      <= tdiv + 2'd1;
    tick16_en <= (tdiv == 2'd3);
  end

  // Strobe monitor
  always @(negedge clk) begin
    if (rx_strobe) begin
      run = run + 1;
      if (run > max_run) max_run = run;
      cap_cnt = cap_cnt + 1;
      cap_d   = rx_byte;
      cap_pe  = rx_par_err;
      cap_fe  = rx_frm_err;
    end else begin
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int ticks);
    rx_line = v;
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [5:0] ctl, input logic [7:0] din, input logic pbit,
                            input logic s1_low, input logic s2_low);
    int nb;
    nb = int'(ctl[1:0]) + 5;
    line_ctl = ctl;
    drive_bit(1'b0, 16);
    for (int i = 0; i < nb; i++) drive_bit(din[i], 16);
    if (ctl[3]) drive_bit(pbit, 16);
    drive_bit(~s1_low, 16);
    if (ctl[2]) drive_bit(~s2_low, (nb == 5) ? 8 : 16);
    drive_bit(1'b1, 32);
  endtask

  task automatic check_frame(input int prev, input logic [7:0] ed, input logic epe,
                             input logic efe, input string tag);
    chk(cap_cnt == prev + 1, {tag, " strobe count (R9)"}, cap_cnt - prev, 1);
    chk(cap_d == ed, {tag, " data"}, int'(cap_d), int'(ed));
    chk(cap_pe == epe, {tag, " parity flag"}, int'(cap_pe), int'(epe));
    chk(cap_fe == efe, {tag, " framing flag"}, int'(cap_fe), int'(efe));
    chk(rx_byte == ed, {tag, " data held R9"}, int'(rx_byte), int'(ed));
  endtask

  initial begin
    int prev;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(rx_strobe == 1'b0 && rx_byte == 8'h00 && rx_par_err == 1'b0 && rx_frm_err == 1'b0,
        "R10 reset outputs", int'({rx_strobe, rx_par_err, rx_frm_err, rx_byte}), 0);
    rst_n = 1'b1;
    repeat (64) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      prev = cap_cnt;
      send_frame(v.ctl, v.din, v.pbit, v.s1_low, v.s2_low);
      check_frame(prev, v.exp_d, v.exp_pe, v.exp_fe, tag);
    end

    // R8: glitch of three ticks is a false start
    prev = cap_cnt;
    drive_bit(1'b0, 3);
    drive_bit(1'b1, 48);
    chk(cap_cnt == prev, "R8 glitch strobe count", cap_cnt - prev, 0);
    chk(rx_byte == 8'h00 && rx_par_err == 1'b1, "R8 outputs untouched", int'(rx_byte), 0);
    prev = cap_cnt;
    send_frame(6'b000011, 8'hC3, 1'b0, 1'b0, 1'b0);
    check_frame(prev, 8'hC3, 1'b0, 1'b0, "R8 after glitch");

    // R10: reset in the middle of a character
    line_ctl = 6'b000011;
    rx_line  = 1'b0;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_strobe == 1'b0 && rx_byte == 8'h00 && rx_par_err == 1'b0 && rx_frm_err == 1'b0,
        "R10 mid-frame reset outputs", int'({rx_strobe, rx_par_err, rx_frm_err, rx_byte}), 0);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    prev = cap_cnt;
    repeat (700) @(negedge clk);
    chk(cap_cnt == prev, "R10 no strobe from abandoned frame", cap_cnt - prev, 0);
    send_frame(6'b000011, 8'h69, 1'b0, 1'b0, 1'b0);
    check_frame(prev, 8'h69, 1'b0, 1'b0, "R10 after reset");

    chk(max_run == 1, "R9 strobe width", max_run, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule